// File: doc/BRIEF.md
# Serial Peripheral Interface Register Front End

This block is the software-visible half of a serial peripheral interface controller. A processor reaches it through a plain 32-bit register bus with word-aligned read and write strobes. The block keeps the controller's configuration word, an on/off bit, two plain storage words (an inter-transfer delay word and an idle-count byte), a TX watermark and a 7-bit interrupt mask. It also contains two byte-wide FIFOs whose depths are parameters. Software pushes transmit bytes and pops received bytes through two data offsets.

The shift engine connects on the other side. It sees the configuration fields, the head of the TX FIFO with a pop strobe, a push port into the RX FIFO, and a mode-fault pulse. A single level interrupt goes high whenever an enabled status bit is set. The mask can only be changed through a pair of write-only set and clear offsets. The watermark register holds only as many bits as a TX level below the FIFO depth needs, so software can find the depth by writing all ones and reading the value back.

Top module: `spi_reg_front`

## Requirements
- R1: After reset the configuration, delay, idle-count, mask and enable registers read 0, the watermark reads 1, the status register reads 0x04, `irq` is low and `txValid` is low.
- R2: Word offset 0x00 (configuration) and 0x18 (delay) store all 32 written bits. Offset 0x24 (idle count) stores the low 8 bits. All three read back what was written. The configuration word also appears on `cfgWord`.
- R3: Writing ones to offset 0x08 sets those bits of the mask. Writing ones to offset 0x0C clears them. Offset 0x10 returns the mask, and writes to 0x10 leave the mask unchanged.
- R4: The status register at offset 0x04 has four live bits. Bit 2 is 1 while the TX level is strictly below the watermark. Bit 3 is 1 while the TX FIFO is full. Bit 4 is 1 while the RX FIFO holds data. Bits 0, 5 and 6 read 0.
- R5: Status bit 1 (mode fault) is set by a `modeFault` pulse and stays set. Writing 1 to status bit 1 clears it. Writing 0 to that bit leaves it set.
- R6: The watermark register at offset 0x28 stores log2(TX depth) bits. Writing 0xFFFF to it reads back TX depth − 1.
- R7: Bit 0 of offset 0x14 drives `ctrlEnable`, and reads back at bit 0. Writing 0 to bit 0 turns the controller off whatever the other bits are.
- R8: A write to offset 0x1C pushes the low byte into the TX FIFO. Bytes leave on `txByte` in push order, one per `txPop`. A push to a full FIFO is dropped.
- R9: Each read of offset 0x20 returns the oldest RX byte and pops it. A read of an empty RX FIFO returns 0 and leaves the FIFO unchanged. A push from the engine into a full RX FIFO is dropped.
- R10: `irq` equals the OR over the seven bits of (status AND mask).
- R11: Read data appears on `busRdata` on the clock edge that samples `busRdEn`, and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busRdEn | input | 1 | Register read strobe |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| cfgWord | output | 32 | Configuration word for the shift engine |
| ctrlEnable | output | 1 | Controller on |
| delayWord | output | 32 | Stored delay word |
| idleCount | output | 8 | Stored idle-count byte |
| txValid | output | 1 | TX FIFO holds data |
| txByte | output | 8 | Oldest TX byte |
| txPop | input | 1 | Engine consumes `txByte` |
| rxPush | input | 1 | Engine delivers a received byte |
| rxByte | input | 8 | Received byte |
| rxFull | output | 1 | RX FIFO full |
| modeFault | input | 1 | Mode-fault pulse from the engine |
| irq | output | 1 | Level interrupt |

## Verification
A register write or FIFO push takes effect on the rising edge that samples it. The status bits, `irq`, `txValid` and the FIFO outputs therefore change one edge after the stimulus. Read data is registered once, so the value for a read strobe is on `busRdata` after that same edge. The bench changes every input at the falling edge and looks at outputs on the next falling edge, half a period after the edge that updates them. One check also looks at `busRdata` while a read is still pending, to confirm that the old value is held until the edge.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  // word indices (byte offset / 4)
  localparam int IDX_CFG  = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_ISET = 2;
  localparam int IDX_ICLR = 3;
  localparam int IDX_MASK = 4;
  localparam int IDX_EN   = 5;
  localparam int IDX_DLY  = 6;
  localparam int IDX_TXD  = 7;
  localparam int IDX_RXD  = 8;
  localparam int IDX_IDLE = 9;
  localparam int IDX_WM   = 10;

  localparam int IRQ_W      = 7;
  localparam int BIT_MODF   = 1;
  localparam int BIT_TXLOW  = 2;
  localparam int BIT_TXFULL = 3;
  localparam int BIT_RXNE   = 4;

  typedef enum logic [3:0] {
    SEL_CFG, SEL_STAT, SEL_MASK, SEL_EN, SEL_DLY,
    SEL_RXD, SEL_IDLE, SEL_WM, SEL_NONE
  } rdSel_e;

  typedef struct packed {
    logic   wrCfg;
    logic   wrStat;
    logic   wrISet;
    logic   wrIClr;
    logic   wrEn;
    logic   wrDly;
    logic   wrTxd;
    logic   wrIdle;
    logic   wrWm;
    logic   rdRxd;
    logic   rdHit;
    rdSel_e rdSel;
  } strobe_t;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
  parameter int DEPTH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] head,
  output logic [$clog2(DEPTH+1)-1:0] level
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && (count != CW'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign head   = mem[rdPtr];
  assign level  = count;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= bump(wrPtr);
      if (doPop)  rdPtr <= bump(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R8
  AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && count == CW'(DEPTH)) |=> (count == CW'(DEPTH))); // R8
  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && count == '0) |=> (count == '0)); // R9
endmodule

// File: rtl/spi_reg_ctrl.sv
module spi_reg_ctrl
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  output strobe_t           stb
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    stb       = '0;
    stb.rdSel = SEL_NONE;
    if (aligned && busWrEn) begin
      case (word)
        WORD_W'(IDX_CFG):  stb.wrCfg  = 1'b1;
        WORD_W'(IDX_STAT): stb.wrStat = 1'b1;
        WORD_W'(IDX_ISET): stb.wrISet = 1'b1;
        WORD_W'(IDX_ICLR): stb.wrIClr = 1'b1;
        WORD_W'(IDX_EN):   stb.wrEn   = 1'b1;
        WORD_W'(IDX_DLY):  stb.wrDly  = 1'b1;
        WORD_W'(IDX_TXD):  stb.wrTxd  = 1'b1;
        WORD_W'(IDX_IDLE): stb.wrIdle = 1'b1;
        WORD_W'(IDX_WM):   stb.wrWm   = 1'b1;
        default: ;
      endcase
    end
    if (aligned && busRdEn) begin
      stb.rdHit = 1'b1;
      case (word)
        WORD_W'(IDX_CFG):  stb.rdSel = SEL_CFG;
        WORD_W'(IDX_STAT): stb.rdSel = SEL_STAT;
        WORD_W'(IDX_MASK): stb.rdSel = SEL_MASK;
        WORD_W'(IDX_EN):   stb.rdSel = SEL_EN;
        WORD_W'(IDX_DLY):  stb.rdSel = SEL_DLY;
        WORD_W'(IDX_IDLE): stb.rdSel = SEL_IDLE;
        WORD_W'(IDX_WM):   stb.rdSel = SEL_WM;
        WORD_W'(IDX_RXD): begin
          stb.rdSel = SEL_RXD;
          stb.rdRxd = 1'b1;
        end
        default: stb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/spi_reg_dp.sv
module spi_reg_dp
  import spi_reg_pkg::*;
#(
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  parameter int IDLE_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [31:0]       cfgWord,
  output logic              ctrlEnable,
  output logic [31:0]       delayWord,
  output logic [IDLE_W-1:0] idleCount,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  output logic              rxFull,
  input  logic              modeFault,
  output logic              irq
);
  localparam int WM_W  = $clog2(TX_DEPTH);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic [WM_W-1:0]  wmReg;
  logic [IRQ_W-1:0] maskReg, statusVec;
  logic             modfLat;
  logic [TX_CW-1:0] txLevel;
  logic [RX_CW-1:0] rxLevel;
  logic [7:0]       rxHead;
  logic             txLow, txFullNow, rxNotEmpty;

  spi_byte_fifo #(.DEPTH(TX_DEPTH)) uTxFifo (
    .clk(clk), .rst_n(rst_n), .push(stb.wrTxd), .din(wdata[7:0]),
    .pop(txPop), .head(txByte), .level(txLevel));

  spi_byte_fifo #(.DEPTH(RX_DEPTH)) uRxFifo (
    .clk(clk), .rst_n(rst_n), .push(rxPush), .din(rxByte),
    .pop(stb.rdRxd), .head(rxHead), .level(rxLevel));

  assign txValid    = (txLevel != '0);
  assign txFullNow  = (txLevel == TX_CW'(TX_DEPTH));
  assign txLow      = (txLevel < TX_CW'(wmReg));
  assign rxNotEmpty = (rxLevel != '0);
  assign rxFull     = (rxLevel == RX_CW'(RX_DEPTH));

  always_comb begin
    statusVec             = '0;
    statusVec[BIT_MODF]   = modfLat;
    statusVec[BIT_TXLOW]  = txLow;
    statusVec[BIT_TXFULL] = txFullNow;
    statusVec[BIT_RXNE]   = rxNotEmpty;
  end

  assign irq = |(statusVec & maskReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfgWord    <= '0;
      delayWord  <= '0;
      idleCount  <= '0;
      ctrlEnable <= 1'b0;
      wmReg      <= WM_W'(1);
      maskReg    <= '0;
      modfLat    <= 1'b0;
    end else begin
      if (stb.wrCfg)  cfgWord    <= wdata;
      if (stb.wrDly)  delayWord  <= wdata;
      if (stb.wrIdle) idleCount  <= wdata[IDLE_W-1:0];
      if (stb.wrEn)   ctrlEnable <= wdata[0];
      if (stb.wrWm)   wmReg      <= wdata[WM_W-1:0];
      if (stb.wrISet)      maskReg <= maskReg | wdata[IRQ_W-1:0];
      else if (stb.wrIClr) maskReg <= maskReg & ~wdata[IRQ_W-1:0];
      if (modeFault)                         modfLat <= 1'b1;
      else if (stb.wrStat && wdata[BIT_MODF]) modfLat <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (stb.rdHit) begin
      case (stb.rdSel)
        SEL_CFG:  rdata <= cfgWord;
        SEL_STAT: rdata <= 32'(statusVec);
        SEL_MASK: rdata <= 32'(maskReg);
        SEL_EN:   rdata <= 32'(ctrlEnable);
        SEL_DLY:  rdata <= delayWord;
        SEL_IDLE: rdata <= 32'(idleCount);
        SEL_WM:   rdata <= 32'(wmReg);
        SEL_RXD:  rdata <= rxNotEmpty ? 32'(rxHead) : 32'd0;
        default:  rdata <= '0;
      endcase
    end
  end

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    stb.wrISet |=> ((maskReg & $past(wdata[IRQ_W-1:0])) == $past(wdata[IRQ_W-1:0]))); // R3
  AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.wrIClr && !stb.wrISet) |=> ((maskReg & $past(wdata[IRQ_W-1:0])) == '0)); // R3
  AST_MODF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (modfLat && !(stb.wrStat && wdata[BIT_MODF])) |=> modfLat); // R5
  AST_MODF_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    modeFault |=> modfLat); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.rdRxd && rxLevel == '0) |=> (rdata == 32'd0)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (maskReg == '0) |-> !irq); // R10
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.rdHit |=> $stable(rdata)); // R11
endmodule

// File: rtl/spi_reg_front.sv
module spi_reg_front
  import spi_reg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [31:0]       cfgWord,
  output logic              ctrlEnable,
  output logic [31:0]       delayWord,
  output logic [7:0]        idleCount,
  output logic              txValid,
  output logic [7:0]        txByte,
  input  logic              txPop,
  input  logic              rxPush,
  input  logic [7:0]        rxByte,
  output logic              rxFull,
  input  logic              modeFault,
  output logic              irq
);
  strobe_t stb;

  spi_reg_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busAddr(busAddr), .stb(stb));

  spi_reg_dp #(.TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH), .IDLE_W(8)) uDp (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wdata(busWdata), .rdata(busRdata),
    .cfgWord(cfgWord), .ctrlEnable(ctrlEnable), .delayWord(delayWord),
    .idleCount(idleCount), .txValid(txValid), .txByte(txByte), .txPop(txPop),
    .rxPush(rxPush), .rxByte(rxByte), .rxFull(rxFull),
    .modeFault(modeFault), .irq(irq));
endmodule

// File: tb/tb_spi_reg_front.sv
module tb_spi_reg_front;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam logic [7:0] A_CFG = 8'h00, A_STAT = 8'h04, A_ISET = 8'h08,
    A_ICLR = 8'h0C, A_MASK = 8'h10, A_EN = 8'h14, A_DLY = 8'h18,
    A_TXD = 8'h1C, A_RXD = 8'h20, A_IDLE = 8'h24, A_WM = 8'h28;

  logic clk = 1'b0, rst_n = 1'b0;
  logic busWrEn = 1'b0, busRdEn = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0, busRdata, cfgWord, delayWord;
  logic ctrlEnable, txValid, rxFull, irq;
  logic [7:0] idleCount, txByte;
  logic txPop = 1'b0, rxPush = 1'b0, modeFault = 1'b0;
  logic [7:0] rxByte = '0;
  int nChecks = 0, nFails = 0;
  logic [31:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_reg_front #(.ADDR_W(8), .TX_DEPTH(DEPTH), .RX_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cfgWord(cfgWord), .ctrlEnable(ctrlEnable), .delayWord(delayWord),
    .idleCount(idleCount), .txValid(txValid), .txByte(txByte), .txPop(txPop),
    .rxPush(rxPush), .rxByte(rxByte), .rxFull(rxFull),
    .modeFault(modeFault), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
    d = busRdata;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic rxDeliver(input logic [7:0] b);
    @(negedge clk); rxPush = 1'b1; rxByte = b;
    @(negedge clk); rxPush = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    busRead(A_STAT, rd); check("R1 status", rd, 32'h04);
    busRead(A_MASK, rd); check("R1 mask", rd, 0);
    busRead(A_WM, rd);   check("R1 watermark", rd, 1);
    busRead(A_EN, rd);   check("R1 enable", rd, 0);
    busRead(A_CFG, rd);  check("R1 cfg", rd, 0);
    busRead(A_DLY, rd);  check("R1 delay", rd, 0);
    busRead(A_IDLE, rd); check("R1 idle", rd, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 txValid", {31'b0, txValid}, 0);

    // R2 storage
    busWrite(A_CFG, 32'hA5A5_1234);
    busRead(A_CFG, rd); check("R2 cfg readback", rd, 32'hA5A5_1234);
    check("R2 cfgWord port", cfgWord, 32'hA5A5_1234);
    busWrite(A_DLY, 32'h0BAD_F00D);
    busRead(A_DLY, rd); check("R2 delay readback", rd, 32'h0BAD_F00D);
    check("R2 delayWord port", delayWord, 32'h0BAD_F00D);
    busWrite(A_IDLE, 32'h0000_01C3);
    busRead(A_IDLE, rd); check("R2 idle readback", rd, 32'hC3);

    // R11 read data held until the edge
    busRead(A_CFG, rd);
    @(negedge clk); busRdEn = 1'b1; busAddr = A_IDLE;
    #1 check("R11 hold before edge", busRdata, 32'hA5A5_1234);
    @(negedge clk); busRdEn = 1'b0;
    check("R11 new data after edge", busRdata, 32'hC3);

    // R7 enable
    busWrite(A_EN, 1);
    check("R7 ctrlEnable on", {31'b0, ctrlEnable}, 1);
    busRead(A_EN, rd); check("R7 enable readback", rd, 1);
    busWrite(A_EN, 32'hFFFF_FFFE);
    check("R7 ctrlEnable off", {31'b0, ctrlEnable}, 0);

    // R6 depth discovery
    busWrite(A_WM, 32'h0000_FFFF);
    busRead(A_WM, rd); check("R6 depth-1", rd, DEPTH - 1);

    // R4 and R8 sweep over watermark and level
    for (int wm = 0; wm < DEPTH; wm++) begin
      busWrite(A_WM, wm);
      for (int lvl = 0; lvl <= DEPTH; lvl++) begin
        busRead(A_STAT, rd);
        check("R4 status vs level", rd,
              ((lvl < wm) ? 32'h4 : 32'h0) | ((lvl == DEPTH) ? 32'h8 : 32'h0));
        busWrite(A_TXD, 32'hABCD_0000 | 32'((wm << 4) | lvl));
      end
      for (int j = 0; j < DEPTH; j++) begin
        check("R8 txValid", {31'b0, txValid}, 1);
        check("R8 order", {24'b0, txByte}, 32'((wm << 4) | j));
        pulse(txPop);
      end
      check("R8 full push dropped", {31'b0, txValid}, 0);
    end

    // R3 mask sweep
    for (int p = 0; p < 128; p++) begin
      busWrite(A_ISET, p);
      busRead(A_MASK, rd); check("R3 set", rd, p);
      busWrite(A_ICLR, 32'h7F);
      busRead(A_MASK, rd); check("R3 clear", rd, 0);
    end
    busWrite(A_ISET, 32'h7F);
    busWrite(A_ICLR, 32'h55);
    busRead(A_MASK, rd); check("R3 partial clear", rd, 32'h2A);
    busWrite(A_MASK, 32'h7F);
    busRead(A_MASK, rd); check("R3 mask read-only", rd, 32'h2A);
    busWrite(A_ICLR, 32'h7F);

    // R5 sticky mode fault
    busWrite(A_WM, 1);
    pulse(modeFault);
    busRead(A_STAT, rd); check("R5 set", rd, 32'h06);
    busWrite(A_STAT, 0);
    busRead(A_STAT, rd); check("R5 zero write keeps", rd, 32'h06);
    busWrite(A_STAT, 32'h7D);
    busRead(A_STAT, rd); check("R5 other bits keep", rd, 32'h06);

    // R10 irq per mask bit: status = modf | txLow
    for (int b = 0; b < 7; b++) begin
      busWrite(A_ISET, 1 << b);
      check("R10 irq single bit", {31'b0, irq}, (b == 1 || b == 2) ? 1 : 0);
      busWrite(A_ICLR, 32'h7F);
    end
    busWrite(A_STAT, 32'h02);
    busRead(A_STAT, rd); check("R5 cleared", rd, 32'h04);

    // R9 RX path
    busWrite(A_ISET, 32'h10);
    check("R10 irq rx empty", {31'b0, irq}, 0);
    rxDeliver(8'h11);
    check("R10 irq rx data", {31'b0, irq}, 1);
    rxDeliver(8'h22); rxDeliver(8'h33); rxDeliver(8'h44);
    check("R9 rxFull", {31'b0, rxFull}, 1);
    rxDeliver(8'h55);
    busRead(A_RXD, rd); check("R9 pop 1", rd, 32'h11);
    busRead(A_RXD, rd); check("R9 pop 2", rd, 32'h22);
    busRead(A_RXD, rd); check("R9 pop 3", rd, 32'h33);
    busRead(A_RXD, rd); check("R9 pop 4 (push to full dropped)", rd, 32'h44);
    busRead(A_RXD, rd); check("R9 empty read zero", rd, 0);
    busRead(A_RXD, rd); check("R9 empty read again", rd, 0);
    check("R10 irq after drain", {31'b0, irq}, 0);
    rxDeliver(8'h66);
    busRead(A_RXD, rd); check("R9 pointers intact", rd, 32'h66);
    busRead(A_STAT, rd); check("R4 rx empty again", rd, 32'h04);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule